// File: doc/BRIEF.md
# Run-Length Pixel Stream Decoder

This block turns a stream of 16-bit command words into a 9-bit RGB pixel output. It runs on a clock four times the pixel rate and takes its words from a FIFO through a ready/valid handshake. Each word carries a colour and a 7-bit control code. The code either sets how long the colour stays on the output, in half-pixel steps from one to four pixels, or parks the decoder until the timing generator sends a frame strobe or a line strobe.

A word's colour reaches the output on the clock after the word is accepted, and stays there until the next word is accepted. A frame wait always goes on into a line wait, so a new frame starts at the first visible pixel of a line. With every word at the minimum hold, the decoder takes one word per pixel time. If the FIFO has nothing to give when a word is due, the last colour stays on the output and an underrun flag is raised until data arrives.

Top module: `rlpix_decoder`

## Requirements
- R1: While reset is applied, and after release until the first frame strobe, `pix_rgb` is 0, `cmd_ready` is 0 and `starve` is 0. A line strobe on its own does not end this state.
- R2: Bits [8:0] of an accepted word appear on `pix_rgb` on the clock after acceptance, and `pix_rgb` changes only on the clock after an acceptance.
- R3: Control code n in 1..7 (bits [15:9]) keeps the colour for 2n+2 clocks. With data waiting, the next word is accepted exactly 2n+2 clocks after this one (1 pixel for n=1, 4 pixels for n=7).
- R4: A control code that is neither 1..7 nor 0x40 nor 0x41 (0, 8 and 0x7F among them) behaves as code 1, which is 4 clocks.
- R5: Control code 0x40 (frame wait) shows its colour and accepts no further word until a frame strobe and then, on a later clock, a line strobe. A line strobe seen before the frame strobe is ignored.
- R6: Control code 0x41 (line wait) shows its colour and holds `cmd_ready` low until `line_go` is high. `cmd_ready` rises in that same clock, so the next word's colour appears one clock after the strobe.
- R7: When a word is due and `cmd_valid` is low, `pix_rgb` keeps its value, `starve` goes high from the next clock, and `cmd_ready` stays high until a word is accepted. `starve` falls on the clock after that acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Decoder clock, four times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_data | input | 16 | Command word: [8:0] colour, [15:9] control code |
| cmd_valid | input | 1 | FIFO has a word on `cmd_data` |
| cmd_ready | output | 1 | Decoder takes the word in this clock |
| frame_go | input | 1 | Frame-data strobe from the timing generator |
| line_go | input | 1 | Line-data strobe from the timing generator |
| pix_rgb | output | 9 | Current pixel colour |
| starve | output | 1 | High while a due word has not yet arrived |

## Verification
The hardest case to reach from the ports is an underrun that starts in the very clock a hold ends. To reach it, the bench withdraws `cmd_valid` right after a 6-clock word and samples on both sides of the clock where the word falls due. A frame wait that meets a line strobe before its frame strobe also needs a set sequence. The bench parks the decoder on a frame-wait word with valid data behind it, pulses the strobes in the wrong order and then in the right order, and checks that the word is taken only at the line strobe that follows the frame strobe.

// File: rtl/rlpix_pkg.sv
package rlpix_pkg;

  typedef enum logic [1:0] {
    ST_FRAME  = 2'd0,
    ST_LINE   = 2'd1,
    ST_HOLD   = 2'd2,
    ST_STARVE = 2'd3
  } rl_state_t;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_FRAME = 2'd1,
    ACT_LINE  = 2'd2
  } rl_act_t;

  function automatic rl_state_t act_to_state(rl_act_t a);
    case (a)
      ACT_FRAME: return ST_FRAME;
      ACT_LINE:  return ST_LINE;
      default:   return ST_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/rlpix_rst_sync.sv
module rlpix_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sr_q[STAGES-1];
endmodule

// File: rtl/rlpix_code_decode.sv
module rlpix_code_decode
  import rlpix_pkg::*;
#(
  parameter int CTRL_W   = 7,
  parameter int HOLD_MAX = 7,
  parameter int HALF_PIX = 2,
  parameter int CNT_W    = 4,
  parameter logic [CTRL_W-1:0] FRAME_CODE = 7'h40,
  parameter logic [CTRL_W-1:0] LINE_CODE  = 7'h41
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output rl_act_t           act_o,
  output logic [CNT_W-1:0]  load_o
);
  int sel_n;

  always_comb begin
    sel_n = int'(ctrl_i);
    if (sel_n < 1 || sel_n > HOLD_MAX) sel_n = 1;
    load_o = CNT_W'(HALF_PIX * (sel_n + 1) - 1);
    if (ctrl_i == FRAME_CODE)     act_o = ACT_FRAME;
    else if (ctrl_i == LINE_CODE) act_o = ACT_LINE;
    else                          act_o = ACT_HOLD;
  end
endmodule

// File: rtl/rlpix_hold_counter.sv
module rlpix_hold_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             cnt_en_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                       cnt_d = load_val_i;
    else if (cnt_en_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/rlpix_decoder.sv
module rlpix_decoder
  import rlpix_pkg::*;
#(
  parameter int CLK_PER_PIX = 4,
  parameter int COLOR_W     = 9,
  parameter int CTRL_W      = 7,
  parameter int HOLD_MAX    = 7,
  parameter int SYNC_STAGES = 2,
  parameter logic [CTRL_W-1:0] FRAME_CODE = 7'h40,
  parameter logic [CTRL_W-1:0] LINE_CODE  = 7'h41,
  localparam int WORD_W = COLOR_W + CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              frame_go,
  input  logic              line_go,
  output logic [COLOR_W-1:0] pix_rgb,
  output logic              starve
);
  localparam int HALF_PIX = CLK_PER_PIX / 2;
  localparam int CNT_W    = $clog2(HALF_PIX * (HOLD_MAX + 1));

  logic               core_rst_n;
  rl_state_t          state_q, state_d;
  rl_act_t            act;
  rl_state_t          act_state;
  logic [CNT_W-1:0]   load_val;
  logic               hold_done;
  logic               accept;
  logic [COLOR_W-1:0] rgb_q;

  rlpix_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (core_rst_n)
  );

  rlpix_code_decode #(
    .CTRL_W     (CTRL_W),
    .HOLD_MAX   (HOLD_MAX),
    .HALF_PIX   (HALF_PIX),
    .CNT_W      (CNT_W),
    .FRAME_CODE (FRAME_CODE),
    .LINE_CODE  (LINE_CODE)
  ) u_dec (
    .ctrl_i (cmd_data[WORD_W-1:COLOR_W]),
    .act_o  (act),
    .load_o (load_val)
  );

  assign act_state = act_to_state(act);
  assign accept    = cmd_ready && cmd_valid;

  rlpix_hold_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .load_i     (accept && (act == ACT_HOLD)),
    .load_val_i (load_val),
    .cnt_en_i   (state_q == ST_HOLD),
    .done_o     (hold_done)
  );

  // next-state and handshake
  always_comb begin
    state_d   = state_q;
    cmd_ready = 1'b0;
    case (state_q)
      ST_FRAME: begin
        if (frame_go) state_d = ST_LINE;
      end
      ST_LINE: begin
        if (line_go) begin
          cmd_ready = 1'b1;
          state_d   = cmd_valid ? act_state : ST_STARVE;
        end
      end
      ST_HOLD: begin
        if (hold_done) begin
          cmd_ready = 1'b1;
          state_d   = cmd_valid ? act_state : ST_STARVE;
        end
      end
      ST_STARVE: begin
        cmd_ready = 1'b1;
        if (cmd_valid) state_d = act_state;
      end
      default: state_d = ST_FRAME;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) state_q <= ST_FRAME;
    else             state_q <= state_d;
  end

  // colour register, enabled by word acceptance
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  rgb_q <= '0;
    else if (accept)  rgb_q <= cmd_data[COLOR_W-1:0];
  end

  assign pix_rgb = rgb_q;
  assign starve  = (state_q == ST_STARVE);
endmodule

// File: rtl/rlpix_checks.sv
module rlpix_checks #(
  parameter int COLOR_W  = 9,
  parameter int CTRL_W   = 7,
  parameter int HOLD_MAX = 7,
  parameter int CLK_PER_PIX = 4,
  parameter logic [CTRL_W-1:0] FRAME_CODE = 7'h40,
  parameter logic [CTRL_W-1:0] LINE_CODE  = 7'h41
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [COLOR_W+CTRL_W-1:0] cmd_data,
  input logic                      cmd_valid,
  input logic                      cmd_ready,
  input logic [COLOR_W-1:0]        pix_rgb,
  input logic                      starve
);
  logic [CTRL_W-1:0] ctrl;
  logic              acc;
  logic              is_hold;
  int                want_len;
  logic              trk_q;
  logic [7:0]        since_q;
  logic [7:0]        exp_q;

  assign ctrl    = cmd_data[COLOR_W+CTRL_W-1:COLOR_W];
  assign acc     = cmd_valid && cmd_ready;
  assign is_hold = (ctrl != FRAME_CODE) && (ctrl != LINE_CODE);

  always_comb begin
    want_len = int'(ctrl);
    if (want_len < 1 || want_len > HOLD_MAX) want_len = 1;
    want_len = (want_len + 1) * (CLK_PER_PIX / 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_q   <= 1'b0;
      since_q <= '0;
      exp_q   <= '0;
    end else if (acc) begin
      trk_q   <= is_hold;
      since_q <= 8'd1;
      exp_q   <= 8'(want_len);
    end else if (cmd_ready) begin
      trk_q <= 1'b0;
    end else if (trk_q) begin
      since_q <= since_q + 8'd1;
    end
  end

  AST_RGB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> pix_rgb == $past(cmd_data[COLOR_W-1:0])); // R2
  AST_RGB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(pix_rgb)); // R2
  AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_q && cmd_ready) |-> since_q == exp_q); // R3
  AST_FRAME_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ctrl == FRAME_CODE) |=> !cmd_ready); // R5
  AST_STARVE_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> starve); // R7
  AST_STARVE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    starve |-> cmd_ready); // R7
  AST_STARVE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !starve); // R7
endmodule

bind rlpix_decoder rlpix_checks #(
  .COLOR_W     (COLOR_W),
  .CTRL_W      (CTRL_W),
  .HOLD_MAX    (HOLD_MAX),
  .CLK_PER_PIX (CLK_PER_PIX),
  .FRAME_CODE  (FRAME_CODE),
  .LINE_CODE   (LINE_CODE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_data  (cmd_data),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .pix_rgb   (pix_rgb),
  .starve    (starve)
);

// File: tb/sim_rlpix_decoder.sv
`timescale 1ns/1ps
module sim_rlpix_decoder;
  logic        clk;
  logic        rst_n;
  logic [15:0] cmd_data;
  logic        cmd_valid;
  logic        cmd_ready;
  logic        frame_go;
  logic        line_go;
  logic [8:0]  pix_rgb;
  logic        starve;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  rlpix_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .frame_go(frame_go), .line_go(line_go),
    .pix_rgb(pix_rgb), .starve(starve)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // word table: {code, colour}, expected hold clocks, requirement
  localparam int NV = 11;
  localparam logic [15:0] VW [NV] = '{
    {7'd1, 9'h155}, {7'd2, 9'h0AA}, {7'd3, 9'h1C7}, {7'd4, 9'h038},
    {7'd5, 9'h1FF}, {7'd6, 9'h001}, {7'd7, 9'h123}, {7'd0, 9'h0F0},
    {7'h7F, 9'h10F}, {7'd8, 9'h066}, {7'h41, 9'h0C3}
  };
  localparam int VL [NV] = '{4, 6, 8, 10, 12, 14, 16, 4, 4, 4, 0};
  localparam int VR [NV] = '{3, 3, 3, 3, 3, 3, 3, 4, 4, 4, 6};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns the cycle in which the word was taken
  task automatic push(input logic [15:0] w, output int t);
    cmd_data  = w;
    cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
    end
    t = cyc;
    @(negedge clk);
    chk(pix_rgb == w[8:0], "R2 colour after accept", int'(pix_rgb), int'(w[8:0]));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    int t, t_prev, c0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0; frame_go = 1'b0; line_go = 1'b0;
    repeat (3) @(negedge clk);
    chk(pix_rgb == 9'd0, "R1 reset colour", int'(pix_rgb), 0);
    chk(cmd_ready == 1'b0, "R1 reset ready", int'(cmd_ready), 0);
    chk(starve == 1'b0, "R1 reset starve", int'(starve), 0);

    rst_n = 1'b1; cmd_valid = 1'b1; cmd_data = {7'd1, 9'h1AB};
    repeat (6) @(negedge clk);
    chk(cmd_ready == 1'b0, "R1 idle until frame strobe", int'(cmd_ready), 0);
    line_go = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R1 line strobe alone ignored", int'(cmd_ready), 0);
    line_go = 1'b0;
    @(negedge clk);
    chk(pix_rgb == 9'd0, "R1 colour still zero", int'(pix_rgb), 0);

    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    #1;
    chk(cmd_ready == 1'b0, "R6 no take before line strobe", int'(cmd_ready), 0);
    repeat (2) @(negedge clk);
    chk(cmd_ready == 1'b0, "R6 still waiting for line", int'(cmd_ready), 0);

    // table walk: starts on the line strobe
    line_go = 1'b1;
    t_prev = 0;
    for (int i = 0; i < NV; i++) begin
      c0 = cyc;
      push(VW[i], t);
      if (i == 0) begin
        line_go = 1'b0;
        chk(t == c0, "R6 word taken in strobe clock", t, c0);
      end else begin
        chk(t - t_prev == VL[i-1], (VR[i-1] == 3) ? "R3 hold length" : "R4 odd code length",
            t - t_prev, VL[i-1]);
      end
      t_prev = t;
    end

    // line-wait word is shown; no data behind it
    cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(cmd_ready == 1'b0, "R6 ready low during line wait", int'(cmd_ready), 0);
    chk(pix_rgb == 9'h0C3, "R6 line-wait colour shown", int'(pix_rgb), 'h0C3);
    line_go = 1'b1;
    #1;
    chk(cmd_ready == 1'b1, "R6 ready with strobe", int'(cmd_ready), 1);
    @(negedge clk);
    line_go = 1'b0;
    chk(starve == 1'b1, "R7 underrun at line start", int'(starve), 1);
    chk(pix_rgb == 9'h0C3, "R7 colour held on underrun", int'(pix_rgb), 'h0C3);
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b1, "R7 ready held while starved", int'(cmd_ready), 1);

    cmd_data = {7'd2, 9'h0AA}; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(pix_rgb == 9'h0AA, "R7 colour after late word", int'(pix_rgb), 'h0AA);
    chk(starve == 1'b0, "R7 starve cleared", int'(starve), 0);
    repeat (5) @(negedge clk);
    chk(starve == 1'b0, "R7 no underrun before due", int'(starve), 0);
    chk(cmd_ready == 1'b1, "R3 due after 6 clocks", int'(cmd_ready), 1);
    @(negedge clk);
    chk(starve == 1'b1, "R7 underrun at hold end", int'(starve), 1);
    chk(pix_rgb == 9'h0AA, "R7 colour kept at hold end", int'(pix_rgb), 'h0AA);

    // frame wait, strobes out of order then in order
    push({7'h40, 9'h111}, t);
    cmd_data = {7'd1, 9'h1F0};
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b0, "R5 frame wait blocks", int'(cmd_ready), 0);
    line_go = 1'b1;
    #1;
    chk(cmd_ready == 1'b0, "R5 early line strobe ignored", int'(cmd_ready), 0);
    @(negedge clk);
    line_go = 1'b0;
    chk(pix_rgb == 9'h111, "R5 frame-wait colour held", int'(pix_rgb), 'h111);
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    #1;
    chk(cmd_ready == 1'b0, "R5 waits on line after frame", int'(cmd_ready), 0);
    @(negedge clk);
    line_go = 1'b1;
    #1;
    chk(cmd_ready == 1'b1, "R5 taken at line strobe", int'(cmd_ready), 1);
    @(negedge clk);
    line_go = 1'b0;
    cmd_valid = 1'b0;
    chk(pix_rgb == 9'h1F0, "R5 first word of frame", int'(pix_rgb), 'h1F0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule